// File: doc/BRIEF.md
# Banked GPIO Register File

This block is a memory-mapped controller for general-purpose I/O lines that are grouped into banks of eight. Each bank owns two byte-wide registers. The first holds the value driven onto output lines. The second selects, line by line, whether the line is an input or an output. A simple 32-bit register bus reaches both registers. The block drives the pad output values and the pad output enables. When software reads a bank's value register, the block returns the live pad level for lines set as inputs and the stored drive value for lines set as outputs.

The bank registers are placed at a stride of eight bytes, starting at offset 8. The window from 0x90 to 0x9F is reserved for an interrupt controller that sits next to this block. Any bank whose natural base would land at or above 0x90 is moved up by 0x10, so no bank register ever decodes inside that window. Every write is masked per bit. A single access can therefore change any subset of the eight lines of one bank and leave the others untouched. The bank count is a parameter. Offsets that map to no register read as zero and ignore writes.

Top module: `gpio_bank_regs`

## Requirements
- R1: Bank b has a base offset of (b+1)*8, plus 0x10 when that value is 0x90 or more. The value register is at base+0 and the mode register is at base+4. Only exact, word-aligned offsets decode.
- R2: A mode bit of 1 makes the line an input (pad_oe low). A mode bit of 0 makes it an output (pad_oe high). Line k of bank b is pad index 8*b+k and register bit k.
- R3: After reset, every mode bit is 1 and every value bit is 0. As a result, pad_oe and pad_out are all zero.
- R4: A write changes only the bits whose bus_wmask bit is 1, setting each to the matching bus_wdata bit. A write with an all-zero mask changes nothing. bus_wdata[31:8] is ignored.
- R5: A read of a value register returns bit k as the pad_in level when line k is an input and as the stored value when it is an output. Bits 31:8 read as zero.
- R6: A read of a mode register returns the mode bits in bits 7:0 and zero in bits 31:8.
- R7: Offsets 0x90 to 0x9F read as zero, and writes to them change no register.
- R8: Every other offset that is not a bank register reads as zero and ignores writes. This covers offsets 0x0 to 0x7, offsets past the last bank, and unaligned offsets.
- R9: Reads are combinational. bus_rdata reflects the current registers and pad_in in the same cycle while bus_sel is high and bus_wr is low, and it is zero otherwise.
- R10: A write takes effect on the clock edge at which it is presented. In any cycle without a write, pad_out and pad_oe do not change on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data, only bits 7:0 used |
| bus_wmask | input | 8 | Per-line write enable |
| bus_rdata | output | 32 | Read data, combinational |
| pad_in | input | NUM_BANKS*8 | Pad input levels |
| pad_out | output | NUM_BANKS*8 | Pad drive values |
| pad_oe | output | NUM_BANKS*8 | Pad output enables (1 = drive) |

## Verification
Read data is due in the same cycle as the read strobe. The driver applies a read after a falling edge and pushes the expected word into a queue. The monitor pops and compares that word one nanosecond after the next rising edge, while the strobe is still held. Write results are due one edge after the write strobe. Pad checks therefore wait until the falling edge that follows that rising edge, when the write has been released. The bench also sets new pad_in levels and reads them back with no clock edge in between, which confirms that input lines pass through combinationally.

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int NUM_BANKS = 20,
  parameter int ADDR_W    = 12,
  parameter int HOLE_LO   = 'h90,
  parameter int HOLE_HI   = 'h9F
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  input  logic [7:0]             bus_wmask,
  output logic [31:0]            bus_rdata,
  input  logic [NUM_BANKS*8-1:0] pad_in,
  output logic [NUM_BANKS*8-1:0] pad_out,
  output logic [NUM_BANKS*8-1:0] pad_oe
);
  localparam int LINES     = 8;
  localparam int NL        = NUM_BANKS * LINES;
  localparam int HOLE_SPAN = HOLE_HI - HOLE_LO + 1;
  localparam int LAST_RAW  = NUM_BANKS * 8;
  localparam int LAST_BASE = (LAST_RAW >= HOLE_LO) ? LAST_RAW + HOLE_SPAN : LAST_RAW;
  localparam int LAST_ADDR = LAST_BASE + 4;

  logic [NUM_BANKS-1:0]       hit_val, hit_mode;
  logic [NUM_BANKS*LINES-1:0] rd_flat;
  logic                       wr_en, rd_en;
  logic [7:0]                 rd_byte;

  assign wr_en = bus_sel &  bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int RAW  = (b + 1) * 8;
    localparam int BASE = (RAW >= HOLE_LO) ? RAW + HOLE_SPAN : RAW;
    localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(BASE + 4);

    logic [7:0] val_q, mode_q, in_b;

    assign hit_val[b]  = (bus_addr == A_VAL);
    assign hit_mode[b] = (bus_addr == A_MODE);
    assign in_b        = pad_in[b*LINES +: LINES];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q  <= '0;
        mode_q <= '1;
      end else if (wr_en) begin
        if (hit_val[b])  val_q  <= (val_q  & ~bus_wmask) | (bus_wdata[7:0] & bus_wmask);
        if (hit_mode[b]) mode_q <= (mode_q & ~bus_wmask) | (bus_wdata[7:0] & bus_wmask);
      end
    end

    assign pad_out[b*LINES +: LINES] = val_q;
    assign pad_oe[b*LINES +: LINES]  = ~mode_q;
    assign rd_flat[b*LINES +: LINES] =
        hit_val[b]  ? ((in_b & mode_q) | (val_q & ~mode_q)) :
        hit_mode[b] ? mode_q : 8'h00;
  end

  always_comb begin
    rd_byte = '0;
    for (int b = 0; b < NUM_BANKS; b++) rd_byte |= rd_flat[b*LINES +: LINES];
  end

  assign bus_rdata = rd_en ? {24'h0, rd_byte} : 32'h0;

  logic rst_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_d <= 1'b1;
    else        rst_d <= 1'b0;

  logic in_hole, past_end;
  assign in_hole  = (int'(bus_addr) >= HOLE_LO) && (int'(bus_addr) <= HOLE_HI);
  assign past_end = int'(bus_addr) > LAST_ADDR;

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_d |-> (pad_oe == '0 && pad_out == '0)); // R3
  AST_ONE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_val, hit_mode})); // R1
  AST_HOLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && in_hole) |-> bus_rdata == 32'h0); // R7
  AST_HOLE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_hole) |=> ($stable(pad_out) && $stable(pad_oe))); // R7
  AST_PAST_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && past_end) |-> bus_rdata == 32'h0); // R8
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pad_out) && $stable(pad_oe))); // R10
  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_wmask == 8'h00) |=> ($stable(pad_out) && $stable(pad_oe))); // R4
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> bus_rdata == 32'h0); // R9
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:8] == 24'h0); // R5
endmodule

// File: tb/test_gpio_bank_regs.sv
module test_gpio_bank_regs;
  localparam int NB = 20;
  localparam int AW = 12;
  localparam int NL = NB * 8;

  logic          clk = 0, rst_n = 0;
  logic          bus_sel = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [7:0]    bus_wmask = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] pad_in, pad_out, pad_oe;

  gpio_bank_regs #(.NUM_BANKS(NB), .ADDR_W(AW)) i_gpio_bank_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wmask(bus_wmask),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe));

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] mval [NB];
  logic [7:0] mmode[NB];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  function automatic int base_of(int b);
    int r = (b + 1) * 8;
    return (r >= 'h90) ? r + 16 : r;
  endfunction

  function automatic logic [31:0] model_read(int a);
    for (int b = 0; b < NB; b++) begin
      if (a == base_of(b))
        return {24'h0, (pad_in[b*8 +: 8] & mmode[b]) | (mval[b] & ~mmode[b])};
      if (a == base_of(b) + 4) return {24'h0, mmode[b]};
    end
    return 32'h0;
  endfunction

  task automatic check(string req, logic [NL-1:0] act, logic [NL-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_pads(string req);
    logic [NL-1:0] eo, ev;
    for (int b = 0; b < NB; b++) begin
      ev[b*8 +: 8] = mval[b];
      eo[b*8 +: 8] = ~mmode[b];
    end
    check({req, " pad_out"}, pad_out, ev);
    check({req, " pad_oe"}, pad_oe, eo);
  endtask

  task automatic bus_write(int a, logic [7:0] v, logic [7:0] m);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = AW'(a);
    bus_wdata = {24'hC3A5F0, v}; bus_wmask = m;
    for (int b = 0; b < NB; b++) begin
      if (a == base_of(b))     mval[b]  = (mval[b]  & ~m) | (v & m);
      if (a == base_of(b) + 4) mmode[b] = (mmode[b] & ~m) | (v & m);
    end
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(int a, string req);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = AW'(a);
    exp_q.push_back(model_read(a));
    tag_q.push_back(req);
    @(negedge clk);
    bus_sel = 0;
  endtask

  always begin
    @(posedge clk);
    #1;
    if (bus_sel && !bus_wr) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: actual %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      pad_in[b*8 +: 8] = 8'(b * 37 + 11);
      mval[b] = 8'h00;
      mmode[b] = 8'hFF;
    end
    repeat (3) @(negedge clk);
    check_pads("R3 in reset");
    rst_n = 1;
    @(negedge clk);
    check_pads("R3 after reset");
    bus_read(base_of(0) + 4, "R3/R6 mode reset");
    bus_read(base_of(0), "R5 all inputs");

    bus_write(base_of(0), 8'hA5, 8'hFF);
    check_pads("R4 full write");
    bus_read(base_of(0), "R5 inputs hide value");

    bus_write(base_of(0) + 4, 8'h00, 8'h0F);
    check_pads("R2 low nibble outputs");
    bus_read(base_of(0), "R5 mixed lines");
    bus_read(base_of(0) + 4, "R6 mode readback");

    bus_write(base_of(0), 8'hFF, 8'h3C);
    check_pads("R4 masked write");
    bus_write(base_of(0), 8'h00, 8'h00);
    check_pads("R4 zero mask");
    bus_read(base_of(0), "R4 masked value");

    bus_write('h88, 8'h5A, 8'hFF);
    bus_write('h8C, 8'h00, 8'hFF);
    check_pads("R1 bank16 at 0x88");
    bus_read('h88, "R1 bank16 read");
    bus_write('hA0, 8'h81, 8'hFF);
    bus_write('hA4, 8'h7E, 8'hFF);
    check_pads("R1 bank17 at 0xA0");
    bus_read('hA4, "R1 bank17 mode");
    bus_write('hB0, 8'hC3, 8'hFF);
    bus_write('hB4, 8'h00, 8'hF0);
    check_pads("R1 last bank at 0xB0");
    bus_read('hB0, "R1 last bank read");

    for (int a = 'h90; a <= 'h9C; a += 4) begin
      bus_write(a, 8'hFF, 8'hFF);
      bus_write(a, 8'h00, 8'hFF);
      check_pads("R7 hole write ignored");
      bus_read(a, "R7 hole read zero");
    end

    bus_write('h0, 8'hFF, 8'hFF);
    bus_write('h4, 8'h00, 8'hFF);
    bus_write('hB8, 8'h00, 8'hFF);
    bus_write('hBC, 8'h00, 8'hFF);
    bus_write('h89, 8'h00, 8'hFF);
    bus_write('h8E, 8'hFF, 8'hFF);
    check_pads("R8 unmapped writes ignored");
    bus_read('h0, "R8 offset 0");
    bus_read('hB8, "R8 past end");
    bus_read('h8A, "R8 unaligned");
    bus_read('h400, "R8 far offset");

    @(negedge clk);
    pad_in[0 +: 8] = 8'h3C;
    pad_in[16*8 +: 8] = 8'hFF;
    bus_sel = 1; bus_wr = 0; bus_addr = AW'(base_of(0));
    exp_q.push_back(model_read(base_of(0))); tag_q.push_back("R9 live pad_in");
    @(negedge clk);
    pad_in[0 +: 8] = 8'hC3;
    exp_q.push_back(model_read(base_of(0))); tag_q.push_back("R9 same-cycle pad_in");
    @(negedge clk);
    bus_sel = 0;
    #1;
    check("R9 idle rdata", NL'(bus_rdata), '0);
    bus_read('h88, "R5 bank16 outputs ignore pad_in");

    repeat (3) @(negedge clk);
    check_pads("R10 idle stable");
    check("R9 queue drained", NL'(exp_q.size()), '0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule